// File: doc/BRIEF.md
# UART Interrupt Combiner

This block merges the interrupt conditions of one UART channel into a single interrupt request line. It watches the fill counts of the transmit and receive FIFOs and compares them against trigger levels that software programs. It also takes pulses for receive timeout, line error and modem events. The conditions set bits in a source register. A mask register hides selected bits. The masked result is held in a pending register, and the interrupt line is the OR of that register.

The block also drives a receive-DMA busy line. The line is high while the receive path is in DMA mode and the receive FIFO holds nothing. Register writes arrive as decoded one-cycle strobes with a shared data word. The current source, pending and mask values are available on readback ports.

The byte step of the trigger levels is a build-time channel parameter.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source, pending and mask registers are zero, and the interrupt and DMA-busy outputs are low.
- R2: The pending output equals the source register AND NOT the mask register as they stood one clock earlier. The interrupt output is high exactly when a pending bit is set.
- R3: A mask write loads `wdata[3:0]` into the mask register. A source bit whose mask bit is set never appears in the pending output and never raises the interrupt.
- R4: Source bit positions are receive = 0, error = 1, transmit = 2 and modem = 3. An error pulse sets bit 1 and a modem pulse sets bit 3. A source-clear write clears the source bits written as 1. A pending-clear write clears the same source bits. If a set condition is true in the same cycle as a clear, the bit stays set.
- R5: FIFO-control bit 0 enables FIFO mode. Its bits [10:8] hold the transmit trigger field and bits [6:4] the receive trigger field. The step is 32 bytes for channel 0, 8 bytes for channels 1 and 4, and 2 bytes for channels 2 and 3. The transmit level is field × step. The receive level is (field + 1) × step.
- R6: In FIFO mode the transmit source bit is set in every cycle where the transmit count is at or below the transmit level.
- R7: In FIFO mode the receive source bit is set when the receive count is at or above the receive level. It is also set when the count is non-zero while control bit 7 (the timeout enable) is clear.
- R8: In FIFO mode with the timeout enabled, a timeout pulse sets the receive source bit if the receive count is non-zero. It has no effect when the count is zero.
- R9: With FIFO mode off, the receive source bit is set while the single-byte ready input is high, and the transmit bit is never set by a level.
- R10: DMA busy is high one clock after a cycle in which control bits [1:0] equal 2'b10 and the receive count is zero. Otherwise it is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdata | input | WD_W | Write data shared by all write strobes |
| wr_fifo_ctl | input | 1 | Load FIFO-control register (enable, trigger fields) |
| wr_ctl | input | 1 | Load channel control register (DMA mode, timeout enable) |
| wr_mask | input | 1 | Load mask register |
| wr_src_clr | input | 1 | Clear source bits written as 1 |
| wr_pend_clr | input | 1 | Clear pending/source bits written as 1 |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_ready | input | 1 | Single-byte receive data ready (FIFO mode off) |
| rx_timeout | input | 1 | Receive timeout pulse |
| err_evt | input | 1 | Line error pulse |
| modem_evt | input | 1 | Modem status change pulse |
| irq | output | 1 | Combined interrupt request |
| dma_busy | output | 1 | Receive DMA busy |
| src_o | output | 4 | Source register readback |
| pend_o | output | 4 | Pending register readback |
| mask_o | output | 4 | Mask register readback |

## Verification
A corrupted source bit shows up on `src_o` in the same cycle. It reaches `pend_o` and `irq` one clock later, unless the mask hides it. A wrong trigger level or step appears as a transmit or receive bit that sets one count too early or too late. This is found by moving the counts across each level and clearing the sources in between. A wrong DMA-mode decode or a wrong empty test shows on `dma_busy` one clock after the count or mode changes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC   = 4;
    localparam int FCR_W  = 11;
    localparam int CTL_W  = 8;

    localparam int SRC_RX    = 0;
    localparam int SRC_ERR   = 1;
    localparam int SRC_TX    = 2;
    localparam int SRC_MODEM = 3;

    localparam int FCR_EN_BIT  = 0;
    localparam int FCR_RX_LSB  = 4;
    localparam int FCR_TX_LSB  = 8;
    localparam int CTL_TMO_BIT = 7;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic [FCR_W-1:0] fcr;
        logic [CTL_W-1:0] ctl;
        src_vec_t         mask;
        src_vec_t         src;
        src_vec_t         pend;
        logic             irq;
        logic             dma;
    } irq_state_t;

    function automatic int trig_step(input int ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level #(
    parameter int CHANNEL = 2,
    parameter int CNT_W   = 8
) (
    input  logic [2:0]       tx_field,
    input  logic [2:0]       rx_field,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output logic             tx_hit,
    output logic             rx_hit,
    output logic             rx_any
);
    localparam int LVL_W = ((CNT_W > 9) ? CNT_W : 9) + 1;

    logic [LVL_W-1:0] tx_lvl;
    logic [LVL_W-1:0] rx_lvl;
    logic [LVL_W-1:0] tx_ext;
    logic [LVL_W-1:0] rx_ext;
    logic [3:0]       rx_mult;

    assign rx_mult = {1'b0, rx_field} + 4'd1;

    // The step is a power of two per channel group, so each variant is a shift.
    generate
        if (uart_irq_pkg::trig_step(CHANNEL) == 32) begin : g_step32
            assign tx_lvl = LVL_W'({tx_field, 5'b0});
            assign rx_lvl = LVL_W'({rx_mult, 5'b0});
        end else if (uart_irq_pkg::trig_step(CHANNEL) == 8) begin : g_step8
            assign tx_lvl = LVL_W'({tx_field, 3'b0});
            assign rx_lvl = LVL_W'({rx_mult, 3'b0});
        end else if (uart_irq_pkg::trig_step(CHANNEL) == 2) begin : g_step2
            assign tx_lvl = LVL_W'({tx_field, 1'b0});
            assign rx_lvl = LVL_W'({rx_mult, 1'b0});
        end else begin : g_step0
            assign tx_lvl = '0;
            assign rx_lvl = '0;
        end
    endgenerate

    assign tx_ext = LVL_W'(tx_count);
    assign rx_ext = LVL_W'(rx_count);

    assign tx_hit = (tx_ext <= tx_lvl);
    assign rx_hit = (rx_ext >= rx_lvl) && (rx_lvl != '0);
    assign rx_any = (rx_count != '0);

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
(
    input  logic     fifo_en,
    input  logic     tmo_en,
    input  logic     tx_hit,
    input  logic     rx_hit,
    input  logic     rx_any,
    input  logic     rx_ready,
    input  logic     rx_timeout,
    input  logic     err_evt,
    input  logic     modem_evt,
    output src_vec_t set_vec
);
    logic rx_fifo_set;

    always_comb begin
        rx_fifo_set = rx_hit
                    | (rx_any & ~tmo_en)
                    | (rx_timeout & tmo_en & rx_any);

        set_vec            = '0;
        set_vec[SRC_RX]    = fifo_en ? rx_fifo_set : rx_ready;
        set_vec[SRC_TX]    = fifo_en & tx_hit;
        set_vec[SRC_ERR]   = err_evt;
        set_vec[SRC_MODEM] = modem_evt;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int CHANNEL = 2,
    parameter int CNT_W   = 8,
    parameter int WD_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WD_W-1:0]  wdata,
    input  logic             wr_fifo_ctl,
    input  logic             wr_ctl,
    input  logic             wr_mask,
    input  logic             wr_src_clr,
    input  logic             wr_pend_clr,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             err_evt,
    input  logic             modem_evt,
    output logic             irq,
    output logic             dma_busy,
    output logic [3:0]       src_o,
    output logic [3:0]       pend_o,
    output logic [3:0]       mask_o
);
    irq_state_t st_q, st_d;
    src_vec_t   set_vec;
    src_vec_t   clr_vec;
    logic       tx_hit, rx_hit, rx_any;

    uart_irq_level #(
        .CHANNEL (CHANNEL),
        .CNT_W   (CNT_W)
    ) u_level (
        .tx_field (st_q.fcr[FCR_TX_LSB +: 3]),
        .rx_field (st_q.fcr[FCR_RX_LSB +: 3]),
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_hit   (tx_hit),
        .rx_hit   (rx_hit),
        .rx_any   (rx_any)
    );

    uart_irq_sources u_sources (
        .fifo_en    (st_q.fcr[FCR_EN_BIT]),
        .tmo_en     (st_q.ctl[CTL_TMO_BIT]),
        .tx_hit     (tx_hit),
        .rx_hit     (rx_hit),
        .rx_any     (rx_any),
        .rx_ready   (rx_ready),
        .rx_timeout (rx_timeout),
        .err_evt    (err_evt),
        .modem_evt  (modem_evt),
        .set_vec    (set_vec)
    );

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (wr_src_clr)  clr_vec = clr_vec | wdata[NSRC-1:0];
        if (wr_pend_clr) clr_vec = clr_vec | wdata[NSRC-1:0];

        if (wr_fifo_ctl) st_d.fcr  = wdata[FCR_W-1:0];
        if (wr_ctl)      st_d.ctl  = wdata[CTL_W-1:0];
        if (wr_mask)     st_d.mask = wdata[NSRC-1:0];

        // Clear first, then this cycle's conditions: a live condition wins.
        st_d.src  = (st_q.src & ~clr_vec) | set_vec;
        st_d.pend = st_q.src & ~st_q.mask;
        st_d.irq  = |(st_q.src & ~st_q.mask);
        st_d.dma  = (st_q.ctl[1:0] == 2'b10) && (rx_count == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq      = st_q.irq;
    assign dma_busy = st_q.dma;
    assign src_o    = st_q.src;
    assign pend_o   = st_q.pend;
    assign mask_o   = st_q.mask;

    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o == $past(src_o & ~mask_o)); // R2
    AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend_o != 4'b0)); // R2
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & $past(mask_o)) == 4'b0); // R3
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> src_o[SRC_ERR]); // R4
    AST_MODEM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        modem_evt |=> src_o[SRC_MODEM]); // R4
    AST_NOFIFO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.fcr[FCR_EN_BIT] && rx_ready) |=> src_o[SRC_RX]); // R9
    AST_DMA_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[1:0] == 2'b10 && rx_count == '0) |=> dma_busy); // R10
    AST_DMA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count != '0) |=> !dma_busy); // R10

endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
    localparam int CLK_P = 10;
    localparam int CH    = 2;
    localparam int CW    = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] wdata = '0;
    logic        wr_fifo_ctl = 0, wr_ctl = 0, wr_mask = 0, wr_src_clr = 0, wr_pend_clr = 0;
    logic [CW-1:0] tx_count = '0, rx_count = '0;
    logic        rx_ready = 0, rx_timeout = 0, err_evt = 0, modem_evt = 0;
    logic        irq, dma_busy;
    logic [3:0]  src_o, pend_o, mask_o;

    int errors = 0, checks = 0, cycles = 0;
    int m_src = 0, m_pend = 0, m_mask = 0, m_fcr = 0, m_ctl = 0, m_irq = 0, m_dma = 0;

    uart_irq_ctrl #(.CHANNEL(CH), .CNT_W(CW), .WD_W(16)) dut (
        .clk, .rst_n, .wdata, .wr_fifo_ctl, .wr_ctl, .wr_mask, .wr_src_clr, .wr_pend_clr,
        .tx_count, .rx_count, .rx_ready, .rx_timeout, .err_evt, .modem_evt,
        .irq, .dma_busy, .src_o, .pend_o, .mask_o
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // One clock: predict from the requirements, advance, compare.
    task automatic cyc();
        int step, txl, rxl, clr, set, fe, te, n_src, n_pend, n_irq, n_dma;
        case (CH)
            0: step = 32; 1, 4: step = 8; 2, 3: step = 2; default: step = 0;
        endcase
        txl = ((m_fcr >> 8) & 7) * step;
        rxl = (((m_fcr >> 4) & 7) + 1) * step;
        fe  = m_fcr & 1;
        te  = (m_ctl >> 7) & 1;
        set = 0;
        if (fe != 0) begin
            if (tx_count <= txl) set |= 4;
            if (rx_count >= rxl) set |= 1;
            if (rx_count > 0 && te == 0) set |= 1;
            if (rx_count > 0 && te == 1 && rx_timeout) set |= 1;
        end else if (rx_ready) set |= 1;
        if (err_evt)   set |= 2;
        if (modem_evt) set |= 8;
        clr = 0;
        if (wr_src_clr)  clr |= wdata & 15;
        if (wr_pend_clr) clr |= wdata & 15;
        n_pend = m_src & ~m_mask & 15;
        n_irq  = (n_pend != 0);
        n_dma  = ((m_ctl & 3) == 2) && (rx_count == 0);
        n_src  = ((m_src & ~clr) | set) & 15;
        @(posedge clk);
        if (!rst_n) begin
            m_src = 0; m_pend = 0; m_mask = 0; m_fcr = 0; m_ctl = 0; m_irq = 0; m_dma = 0;
        end else begin
            if (wr_fifo_ctl) m_fcr = wdata & 16'h7FF;
            if (wr_ctl)      m_ctl = wdata & 16'hFF;
            if (wr_mask)     m_mask = wdata & 15;
            m_src = n_src; m_pend = n_pend; m_irq = n_irq; m_dma = n_dma;
        end
        #(CLK_P/4);
        check("R4 src", src_o, m_src);
        check("R2 pend", pend_o, m_pend);
        check("R3 mask", mask_o, m_mask);
        check("R2 irq", irq, m_irq);
        check("R10 dma", dma_busy, m_dma);
    endtask

    task automatic wr(int kind, int data);
        wdata = data[15:0];
        case (kind)
            0: wr_fifo_ctl = 1; 1: wr_ctl = 1; 2: wr_mask = 1;
            3: wr_src_clr = 1;  default: wr_pend_clr = 1;
        endcase
        cyc();
        {wr_fifo_ctl, wr_ctl, wr_mask, wr_src_clr, wr_pend_clr} = '0;
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        check("R1 src", src_o, 0); check("R1 pend", pend_o, 0); check("R1 mask", mask_o, 0);
        check("R1 irq", irq, 0);   check("R1 dma", dma_busy, 0);

        // R4 error pulse, then R2 pending/irq one clock later
        err_evt = 1; cyc(); err_evt = 0;
        check("R4 err bit", src_o[1], 1);
        check("R2 pend lag", pend_o[1], 0);
        cyc();
        check("R2 pend", pend_o[1], 1); check("R2 irq", irq, 1);
        wr(4, 2);
        check("R4 pend clr clears src", src_o[1], 0);

        // R3 masking
        wr(2, 2);
        err_evt = 1; cyc(); err_evt = 0; cyc(); cyc();
        check("R3 masked pend", pend_o[1], 0); check("R3 masked irq", irq, 0);
        wr(2, 0); cyc();
        check("R2 unmasked pend", pend_o[1], 1); check("R2 unmasked irq", irq, 1);
        wr(3, 15);

        // R4 modem set and source-clear write
        modem_evt = 1; cyc(); modem_evt = 0;
        check("R4 modem bit", src_o[3], 1);
        wr(3, 8);
        check("R4 src clr", src_o[3], 0);

        // R5/R6 transmit level: field 3, step 2 -> level 6; rx field 1 -> level 4
        tx_count = 7; rx_count = 0;
        wr(1, 16'h80);
        wr(0, 16'h311);
        wr(3, 15); cyc();
        check("R6 tx above level", src_o[2], 0);
        tx_count = 6; cyc();
        check("R6 R5 tx at level", src_o[2], 1);
        tx_count = 7;

        // R7 receive level
        rx_count = 3; wr(3, 15); cyc();
        check("R7 rx below level", src_o[0], 0);
        rx_count = 4; cyc();
        check("R7 R5 rx at level", src_o[0], 1);
        wr(1, 0); rx_count = 1;
        wr(3, 1);
        check("R7 R4 data no timeout, set wins", src_o[0], 1);

        // R8 timeout
        wr(1, 16'h80); wr(3, 15); cyc();
        check("R8 no pulse", src_o[0], 0);
        rx_timeout = 1; cyc(); rx_timeout = 0;
        check("R8 timeout sets", src_o[0], 1);
        rx_count = 0; wr(3, 15);
        rx_timeout = 1; cyc(); rx_timeout = 0;
        check("R8 empty timeout ignored", src_o[0], 0);

        // R9 FIFOs disabled
        wr(0, 0); tx_count = 0; wr(3, 15); cyc();
        check("R9 no tx level", src_o[2], 0);
        rx_ready = 1; cyc(); rx_ready = 0;
        check("R9 ready sets rx", src_o[0], 1);

        // R10 DMA busy
        wr(1, 2); rx_count = 0; cyc();
        check("R10 busy", dma_busy, 1);
        rx_count = 1; cyc();
        check("R10 not empty", dma_busy, 0);
        wr(1, 3); rx_count = 0; cyc();
        check("R10 other mode", dma_busy, 0);

        // R5 R6 R7 mixed stimulus against the model
        for (int i = 0; i < 400; i++) begin
            tx_count   = CW'($urandom_range(0, 20));
            rx_count   = CW'($urandom_range(0, 20));
            rx_ready   = $urandom_range(0, 1) != 0;
            rx_timeout = $urandom_range(0, 3) == 0;
            err_evt    = $urandom_range(0, 7) == 0;
            modem_evt  = $urandom_range(0, 7) == 0;
            wdata      = 16'($urandom);
            case ($urandom_range(0, 9))
                0: wr_fifo_ctl = 1; 1: wr_ctl = 1; 2: wr_mask = 1;
                3: wr_src_clr = 1;  4: wr_pend_clr = 1; default: ;
            endcase
            cyc();
            {wr_fifo_ctl, wr_ctl, wr_mask, wr_src_clr, wr_pend_clr} = '0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule